// File: doc/BRIEF.md
# Aperture Address Remapper

The remapper sits on the request path from one bus master to several target slaves. It splits the master's 32-bit address space into sixteen 256 MB windows, one per value of the top address nibble. For each window a programmable table gives a 4-bit slave index and a 4-bit replacement for the top nibble. Each request address is turned into a slave index, a translated address and a flag that says whether the window is mapped to any slave.

Software programs the table through a small register port. There are two slave-select words and two offset words, and each word holds eight 4-bit fields. These writes go to a shadow copy. A write of 1 to a separate commit register copies the whole shadow table into the active table that translation uses. Software can therefore rebuild the map field by field without ever exposing a half-written map to the master. Register reads return the shadow copy.

Top module: `aperture_remap`

## Requirements
- R1: After reset, all shadow and active fields are 0. Every register reads 0, `rsp_valid` and `rsp_mapped` are 0, and every request is reported as unmapped.
- R2: A write to byte offset 0x0, 0x4, 0x8 or 0xC stores `reg_wdata` in the shadow word at that offset, and a read of that offset returns the word. Offset 0x0 holds the slave selects of windows 0–7 and 0x4 those of windows 8–15. Offset 0x8 holds the offsets of windows 0–7 and 0xC those of windows 8–15. Window i of a group sits in bits [4i+3:4i].
- R3: Reads of any other offset, including the commit register 0x10 and unaligned offsets, return 0. Writes to offsets other than 0x0, 0x4, 0x8, 0xC and 0x10 change no register.
- R4: Shadow writes do not change translation until a commit.
- R5: A write to offset 0x10 with `reg_wdata[0]`=1 copies the shadow table into the active table at that clock edge. A request captured at the same edge still uses the old table. A write there with bit 0 = 0 commits nothing.
- R6: The window index is `req_addr[31:28]`, and `rsp_slave` is the active slave-select field of that window.
- R7: `rsp_addr` is the active offset field of the window in bits [31:28], followed by `req_addr[27:0]` unchanged.
- R8: A slave-select field of 0 means the window is unmapped. For a request to such a window, `rsp_mapped` is 0 and `rsp_slave` is 0. For any other value, `rsp_mapped` is 1.
- R9: Responses are registered with one cycle of latency: `rsp_valid` follows `req_valid` one edge later. In a cycle with no request, `rsp_slave` and `rsp_addr` hold their values and `rsp_mapped` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Shadow register read data (combinational) |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 32 | Master request address |
| rsp_valid | output | 1 | Registered response valid |
| rsp_mapped | output | 1 | Window maps to a slave |
| rsp_slave | output | 4 | Selected slave index |
| rsp_addr | output | 32 | Translated address |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 4-bit window index and 4-bit fields, which give sixteen windows packed into two 32-bit words per table. At this size every window can be visited, so each field position of both words and both group halves can be checked. The directed phases program a map and check that it has no effect before a commit, after a zero-valued commit write, or after writes to undefined offsets. They then commit the map, and issue a request in the very cycle of a commit to expose the old-versus-new table boundary. A pseudo-random address phase follows.

// File: rtl/remap_pkg.sv
package remap_pkg;

  typedef enum logic [2:0] {
    REG_SEL_LO,
    REG_SEL_HI,
    REG_OFF_LO,
    REG_OFF_HI,
    REG_COMMIT,
    REG_NONE
  } reg_id_e;

  localparam logic [7:0] OFS_SEL_LO = 8'h00;
  localparam logic [7:0] OFS_SEL_HI = 8'h04;
  localparam logic [7:0] OFS_OFF_LO = 8'h08;
  localparam logic [7:0] OFS_OFF_HI = 8'h0C;
  localparam logic [7:0] OFS_COMMIT = 8'h10;

  function automatic reg_id_e decode_reg(input logic [7:0] ofs);
    case (ofs)
      OFS_SEL_LO: decode_reg = REG_SEL_LO;
      OFS_SEL_HI: decode_reg = REG_SEL_HI;
      OFS_OFF_LO: decode_reg = REG_OFF_LO;
      OFS_OFF_HI: decode_reg = REG_OFF_HI;
      OFS_COMMIT: decode_reg = REG_COMMIT;
      default:    decode_reg = REG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5,
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [TW-1:0] act_sel,
  output logic [TW-1:0] act_off
);

  logic [TW-1:0] sh_sel_q, sh_sel_d;
  logic [TW-1:0] sh_off_q, sh_off_d;
  logic [TW-1:0] act_sel_q, act_sel_d;
  logic [TW-1:0] act_off_q, act_off_d;
  logic [7:0]    ofs;
  reg_id_e       id;
  logic          commit;

  assign ofs    = 8'(addr);
  assign id     = decode_reg(ofs);
  assign commit = we && (id == REG_COMMIT) && wdata[0];

  always_comb begin
    sh_sel_d = sh_sel_q;
    sh_off_d = sh_off_q;
    if (we) begin
      case (id)
        REG_SEL_LO: sh_sel_d[DW-1:0]  = wdata;
        REG_SEL_HI: sh_sel_d[TW-1:DW] = wdata;
        REG_OFF_LO: sh_off_d[DW-1:0]  = wdata;
        REG_OFF_HI: sh_off_d[TW-1:DW] = wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    act_sel_d = act_sel_q;
    act_off_d = act_off_q;
    if (commit) begin
      act_sel_d = sh_sel_q;
      act_off_d = sh_off_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_sel_q  <= '0;
      sh_off_q  <= '0;
      act_sel_q <= '0;
      act_off_q <= '0;
    end else begin
      sh_sel_q  <= sh_sel_d;
      sh_off_q  <= sh_off_d;
      act_sel_q <= act_sel_d;
      act_off_q <= act_off_d;
    end
  end

  always_comb begin
    case (id)
      REG_SEL_LO: rdata = sh_sel_q[DW-1:0];
      REG_SEL_HI: rdata = sh_sel_q[TW-1:DW];
      REG_OFF_LO: rdata = sh_off_q[DW-1:0];
      REG_OFF_HI: rdata = sh_off_q[TW-1:DW];
      default:    rdata = '0;
    endcase
  end

  assign act_sel = act_sel_q;
  assign act_off = act_off_q;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_sel_q) && $stable(act_off_q))); // R4

  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act_sel_q == $past(sh_sel_q) && act_off_q == $past(sh_off_q))); // R5

  AST_UNDEF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && id == REG_NONE) |=> ($stable(sh_sel_q) && $stable(sh_off_q))); // R3

endmodule

// File: rtl/remap_xlate.sv
module remap_xlate #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int FIELD_W = 4,
  parameter int TW      = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [TW-1:0]      act_sel,
  input  logic [TW-1:0]      act_off,
  output logic               rsp_valid,
  output logic               rsp_mapped,
  output logic [FIELD_W-1:0] rsp_slave,
  output logic [ADDR_W-1:0]  rsp_addr
);

  localparam int NUM_AP = 1 << IDX_W;
  localparam int LOW_W  = ADDR_W - IDX_W;

  logic [FIELD_W-1:0] sel_field [NUM_AP];
  logic [FIELD_W-1:0] off_field [NUM_AP];

  for (genvar g = 0; g < NUM_AP; g++) begin : g_field
    assign sel_field[g] = act_sel[g*FIELD_W +: FIELD_W];
    assign off_field[g] = act_off[g*FIELD_W +: FIELD_W];
  end

  logic [IDX_W-1:0]   idx;
  logic [FIELD_W-1:0] sel_pick, off_pick;
  logic               valid_d, mapped_d, cap_en;
  logic [FIELD_W-1:0] slave_d;
  logic [ADDR_W-1:0]  addr_d;

  assign idx      = req_addr[ADDR_W-1 -: IDX_W];
  assign sel_pick = sel_field[idx];
  assign off_pick = off_field[idx];
  assign cap_en   = req_valid;

  always_comb begin
    valid_d  = req_valid;
    mapped_d = req_valid && (sel_pick != '0);
    slave_d  = sel_pick;
    addr_d   = {off_pick[IDX_W-1:0], req_addr[LOW_W-1:0]};
  end

  logic               valid_q, mapped_q;
  logic [FIELD_W-1:0] slave_q;
  logic [ADDR_W-1:0]  addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      mapped_q <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      mapped_q <= mapped_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slave_q <= '0;
      addr_q  <= '0;
    end else if (cap_en) begin
      slave_q <= slave_d;
      addr_q  <= addr_d;
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_mapped = mapped_q;
  assign rsp_slave  = slave_q;
  assign rsp_addr   = addr_q;

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_mapped && $stable(rsp_addr) && $stable(rsp_slave))); // R9

  AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_addr[LOW_W-1:0] == $past(req_addr[LOW_W-1:0]))); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_mapped) |-> (rsp_slave == '0)); // R8

endmodule

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int FIELD_W = 4,
  parameter int DW      = 32,
  parameter int AW      = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic               rsp_mapped,
  output logic [FIELD_W-1:0] rsp_slave,
  output logic [ADDR_W-1:0]  rsp_addr
);

  localparam int NUM_AP = 1 << IDX_W;
  localparam int TW     = NUM_AP * FIELD_W;

  logic [TW-1:0] act_sel, act_off;

  remap_regs #(.DW(DW), .AW(AW), .TW(TW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .act_sel (act_sel),
    .act_off (act_off)
  );

  remap_xlate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .FIELD_W(FIELD_W), .TW(TW)) u_xlate (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .act_sel    (act_sel),
    .act_off    (act_off),
    .rsp_valid  (rsp_valid),
    .rsp_mapped (rsp_mapped),
    .rsp_slave  (rsp_slave),
    .rsp_addr   (rsp_addr)
  );

endmodule

// File: tb/sim_aperture_remap.sv
`timescale 1ns/1ps
module sim_aperture_remap;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_mapped;
  logic [3:0]  rsp_slave;
  logic [31:0] rsp_addr;

  always #5 clk = ~clk;

  aperture_remap u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_mapped(rsp_mapped),
    .rsp_slave(rsp_slave), .rsp_addr(rsp_addr)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  string tag = "R1";

  // Behavioural reference model
  logic [3:0]  ms_sel [16];
  logic [3:0]  ms_off [16];
  logic [3:0]  ma_sel [16];
  logic [3:0]  ma_off [16];
  logic        e_valid, e_mapped;
  logic [3:0]  e_slave;
  logic [31:0] e_addr;

  function automatic logic [31:0] pack8(input logic [3:0] t [16], input int base);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) w[4*k +: 4] = t[base + k];
    return w;
  endfunction

  function automatic logic [31:0] exp_read(input logic [4:0] a);
    case (a)
      5'h00: return pack8(ms_sel, 0);
      5'h04: return pack8(ms_sel, 8);
      5'h08: return pack8(ms_off, 0);
      5'h0C: return pack8(ms_off, 8);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) begin
        ms_sel[k] = '0; ms_off[k] = '0; ma_sel[k] = '0; ma_off[k] = '0;
      end
      e_valid = 0; e_mapped = 0; e_slave = '0; e_addr = '0;
    end else begin
      if (req_valid) begin
        int i;
        i = int'(req_addr[31:28]);
        e_valid  = 1;
        e_slave  = ma_sel[i];
        e_mapped = (ma_sel[i] != 0);
        e_addr   = {ma_off[i], req_addr[27:0]};
      end else begin
        e_valid = 0; e_mapped = 0;
      end
      if (reg_we && reg_addr == 5'h10 && reg_wdata[0]) begin
        for (int k = 0; k < 16; k++) begin
          ma_sel[k] = ms_sel[k]; ma_off[k] = ms_off[k];
        end
      end
      if (reg_we) begin
        for (int k = 0; k < 8; k++) begin
          case (reg_addr)
            5'h00: ms_sel[k]     = reg_wdata[4*k +: 4];
            5'h04: ms_sel[k + 8] = reg_wdata[4*k +: 4];
            5'h08: ms_off[k]     = reg_wdata[4*k +: 4];
            5'h0C: ms_off[k + 8] = reg_wdata[4*k +: 4];
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    chk("rsp_valid (R9)", 32'(rsp_valid), 32'(e_valid));
    chk("rsp_mapped (R8)", 32'(rsp_mapped), 32'(e_mapped));
    chk("rsp_slave (R6)", 32'(rsp_slave), 32'(e_slave));
    chk("rsp_addr (R7)", rsp_addr, e_addr);
    chk("reg_rdata (R2)", reg_rdata, exp_read(reg_addr));
  end

  task automatic step(input logic we, input logic [4:0] a, input logic [31:0] d,
                      input logic rv, input logic [31:0] ra);
    @(posedge clk); #1;
    reg_we = we; reg_addr = a; reg_wdata = d; req_valid = rv; req_addr = ra;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, reg_addr, 0, 0, req_addr);
  endtask

  task automatic sweep();
    for (int w = 0; w < 16; w++) step(0, 5'h00, 0, 1, {w[3:0], 28'h0ABCDE0 + 28'(w)});
    idle(1);
  endtask

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int a = 0; a < 24; a += 4) step(0, 5'(a), 0, 0, 0);
    step(0, 5'h00, 0, 1, 32'h8000_1234);
    step(0, 5'h00, 0, 1, 32'hF000_0004);
    idle(2);

    tag = "R2";
    step(1, 5'h00, 32'h0000_0321, 0, 0);
    step(1, 5'h04, 32'h4567_0A0B, 0, 0);
    step(1, 5'h08, 32'hFEDC_BA98, 0, 0);
    step(1, 5'h0C, 32'h7654_3210, 0, 0);
    for (int a = 0; a < 16; a += 4) step(0, 5'(a), 0, 0, 0);

    tag = "R4";
    sweep();

    tag = "R5";
    step(1, 5'h10, 32'hFFFF_FFFE, 0, 0);
    sweep();
    step(1, 5'h10, 32'h1, 1, 32'h1000_0040);
    step(0, 5'h00, 0, 1, 32'h1000_0040);
    idle(1);

    tag = "R6";
    sweep();

    tag = "R3";
    step(1, 5'h14, 32'hFFFF_FFFF, 0, 0);
    step(1, 5'h02, 32'hFFFF_FFFF, 0, 0);
    step(1, 5'h1C, 32'hFFFF_FFFF, 0, 0);
    for (int a = 0; a < 32; a++) step(0, 5'(a), 0, 0, 0);
    step(1, 5'h10, 32'h1, 0, 0);
    sweep();

    tag = "R8";
    step(1, 5'h04, 32'h0000_0000, 0, 0);
    step(1, 5'h10, 32'h1, 0, 0);
    sweep();

    tag = "R9";
    step(0, 5'h00, 0, 1, 32'h2345_6789);
    idle(4);
    step(0, 5'h00, 0, 1, 32'h0FFF_FFFF);
    step(0, 5'h00, 0, 0, 32'h3111_1111);
    idle(3);

    tag = "R7";
    lfsr = 32'hACE1_2357;
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (n % 50 == 10) step(1, 5'(4 * (n % 4)), lfsr ^ 32'h5A5A_5A5A, 0, 0);
      else if (n % 50 == 20) step(1, 5'h10, 32'h1, lfsr[0], lfsr);
      else step(0, 5'h00, 0, lfsr[3], lfsr);
    end
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule